// File: doc/BRIEF.md
# Flash Command Packet Decoder

This block sits behind a packet transport and watches a byte stream that carries framed host packets, each one marked by a start-of-packet and an end-of-packet flag on its first and last byte. It picks out the packet that opens a serial-flash command, reads the little-endian length and flag words from its header, and checks the requested lane mode, double-rate clocking and dummy cycles against a capability bitmap that the surrounding system advertises. It then follows the write payload of that command across as many continuation packets as the host sends, until the byte total matches what the flag word and count require.

The block produces one of two results for each command. An accepted command gives a descriptor that a downstream flash sequencer can act on: opcode length, address length, lane mode, lane width, double rate, dummy cycles, write-enable, busy-poll, direction and count. The descriptor is held until the sequencer takes it. A rejected command gives a one-cycle error strobe with a 16-bit code, and the command is discarded. The payload bytes themselves are only counted here; moving them is left to other logic.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A packet whose first two bytes, read little-endian, equal START_ID (default 9) while no command is open opens a command: bytes 2..3 are the zero-based count and bytes 4..7 the flag word, both little-endian, and bytes from index 8 on are payload.
- R2: The descriptor fields come from the flag word as: opcode length bits 1:0, address length bits 4:2, mode bits 6:5, width bits 8:7, double rate bit 9, dummy cycles bits 14:10, write-enable bit 28, busy-poll bit 29, write (1) or read (0) bit 31; the count is the header count unchanged.
- R3: If capability bit 1 is clear, an opening packet is rejected with code 0x0008, ahead of every other check.
- R4: A nonzero flag bit in 15..27 or at 30 rejects the command with the malformed code 0x0002.
- R5: With lane width code w (0..3 for 1, 2, 4, 8 lanes), a nonzero mode with w>0 needs capability bit w+1; the double-rate bit needs capability bit 5; a nonzero dummy count needs at least one of capability bits 2..4. A missing capability gives code 0x000A. With mode 0 the width field is not checked.
- R6: The command is accepted, and the descriptor raised, at the end of the packet where the payload total over all its packets reaches opcode length + address length + write-enable + (count+1 when a write); that final packet may have an odd length.
- R7: Code 0x0002 is also raised for: an opening packet shorter than 8 bytes, a payload total that exceeds the required total, a non-final packet with an odd payload, and a packet whose id is not CONT_ID (default 5) while continuation is awaited.
- R8: The descriptor stays valid and unchanged until desc_accept is seen; any packet whose start byte arrives while a descriptor is held, including in the accept cycle, is ignored entirely.
- R9: While no command is open, packets with any id other than START_ID, and packets shorter than two bytes, produce no output.
- R10: After reset desc_valid and err_valid are low and err_code is zero.
- R11: Results appear in the cycle after the end-of-packet byte; err_valid lasts exactly one cycle and never coincides with desc_valid; checks rank capability bit 1, short header, reserved bits, unsupported features, then length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte present on in_data |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | Byte is first of a packet |
| in_eop | input | 1 | Byte is last of a packet |
| cap_bits | input | CAP_W | Advertised capability bitmap |
| desc_accept | input | 1 | Sequencer takes the held descriptor |
| desc_valid | output | 1 | Descriptor held |
| desc_write | output | 1 | Write (1) or read (0) |
| desc_poll | output | 1 | Busy polling after the write |
| desc_wren | output | 1 | Write enable before the command |
| desc_dummy | output | 5 | Dummy cycle count |
| desc_dtr | output | 1 | Double rate in wide phases |
| desc_width | output | 2 | Lane width code |
| desc_mode | output | 2 | Phase at which wide lanes begin |
| desc_addr_len | output | 3 | Address byte count |
| desc_op_len | output | 2 | Opcode byte count |
| desc_count | output | 16 | Zero-based data count |
| err_valid | output | 1 | One-cycle rejection strobe |
| err_code | output | 16 | Code of the last rejection |

## Verification
The hardest state to reach is a command spread over several packets where the length verdict depends on the very last byte: the total must reach the target exactly at an end-of-packet, overshoot by one, or stop short on an odd packet. The stimulus builds write commands whose required total exceeds one packet and splits the payload into even first pieces and an odd final piece, or deliberately into an odd middle piece, while a behavioural packet model in the bench recomputes the verdict from the byte queue on every clock. Packets that start in the same cycle as the descriptor is accepted are also driven, to reach the drop rule at its boundary.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned FLAG_W = 32;

  localparam logic [15:0] ERR_UNEXPECTED = 16'h0008;
  localparam logic [15:0] ERR_MALFORMED  = 16'h0002;
  localparam logic [15:0] ERR_UNSUP_MODE = 16'h000A;

  // bits 27..15 and bit 30 must stay clear
  localparam logic [FLAG_W-1:0] RSVD_MASK = 32'h4FFF_8000;

  typedef enum logic [1:0] {CMD_IDLE, CMD_COLL, CMD_HOLD} cmd_e;

  typedef struct packed {
    logic             write;
    logic             poll;
    logic             wren;
    logic [4:0]       dummy;
    logic             dtr;
    logic [1:0]       width;
    logic [1:0]       mode;
    logic [2:0]       addr_len;
    logic [1:0]       op_len;
    logic [CNT_W-1:0] count;
  } desc_t;

  function automatic desc_t decode_flags(input logic [FLAG_W-1:0] f,
                                         input logic [CNT_W-1:0] c);
    desc_t d;
    d.op_len   = f[1:0];
    d.addr_len = f[4:2];
    d.mode     = f[6:5];
    d.width    = f[8:7];
    d.dtr      = f[9];
    d.dummy    = f[14:10];
    d.wren     = f[28];
    d.poll     = f[29];
    d.write    = f[31];
    d.count    = c;
    return d;
  endfunction
endpackage

// File: rtl/fcd_hdr_parse.sv
module fcd_hdr_parse #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned HDR_B = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat,
  input  logic                 sop,
  input  logic [7:0]           data,
  input  logic                 cap_en,
  input  logic                 hold,
  output logic [IDX_W-1:0]     bidx,
  output logic [15:0]          id_now,
  output logic [8*HDR_B-1:0]   hdr_now,
  output logic                 drop_now
);
  localparam int unsigned FIRST   = 2;
  localparam int unsigned PAY_OFF = FIRST + HDR_B;

  logic [IDX_W-1:0]   idx_q;
  logic [7:0]         id_lo_q;
  logic [15:0]        id_q;
  logic [8*HDR_B-1:0] hdr_q;
  logic               drop_q;
  logic               wr_en;

  assign bidx     = sop ? '0 : idx_q;
  assign drop_now = sop ? hold : drop_q;
  assign id_now   = (bidx == IDX_W'(1)) ? {data, id_lo_q} : id_q;
  assign wr_en    = beat && cap_en && !drop_now;

  for (genvar k = 0; k < HDR_B; k++) begin : g_hdr
    assign hdr_now[8*k +: 8] =
      (wr_en && bidx == IDX_W'(k + FIRST)) ? data : hdr_q[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      id_lo_q <= '0;
      id_q    <= '0;
      hdr_q   <= '0;
      drop_q  <= 1'b0;
    end else if (beat) begin
      idx_q  <= (bidx == IDX_W'(PAY_OFF)) ? bidx : bidx + 1'b1;
      hdr_q  <= hdr_now;
      drop_q <= drop_now;
      if (bidx == IDX_W'(0)) id_lo_q <= data;
      if (bidx == IDX_W'(1)) id_q    <= {data, id_lo_q};
    end
  end
endmodule

// File: rtl/fcd_flag_check.sv
module fcd_flag_check
  import fcd_pkg::*;
#(
  parameter int unsigned CAP_W = 16,
  parameter int unsigned LEN_W = CNT_W + 2
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [CAP_W-1:0]  caps,
  input  logic [CNT_W-1:0]  count,
  output logic              ext_off,
  output logic              rsvd_bad,
  output logic              unsup,
  output logic [LEN_W-1:0]  need
);
  desc_t      f;
  logic [2:0] lane_cap;
  logic       lane_ok;

  assign f        = decode_flags(flags, count);
  assign lane_cap = caps[4:2];
  assign lane_ok  = (f.width == 2'd0) ? 1'b1 : lane_cap[f.width - 2'd1];
  assign ext_off  = !caps[1];
  assign rsvd_bad = |(flags & RSVD_MASK);
  assign unsup    = ((f.mode != 2'd0) && !lane_ok) ||
                    (f.dtr && !caps[5]) ||
                    ((f.dummy != 5'd0) && (lane_cap == 3'd0));
  assign need     = LEN_W'(f.op_len) + LEN_W'(f.addr_len) + LEN_W'(f.wren) +
                    (f.write ? LEN_W'(count) + LEN_W'(1) : '0);

  if (CAP_W > 6) begin : g_spare
    logic unused_caps;
    assign unused_caps = ^{caps[CAP_W-1:6], caps[0]};
  end else begin : g_nospare
    logic unused_caps;
    assign unused_caps = caps[0];
  end
endmodule

// File: rtl/fcd_len_track.sv
module fcd_len_track #(
  parameter int unsigned LEN_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             pkt_start,
  input  logic             pay,
  input  logic [LEN_W-1:0] need,
  output logic [LEN_W-1:0] total_now,
  output logic             over_now,
  output logic             odd_now
);
  logic [LEN_W-1:0] total_q;
  logic             over_q;
  logic             odd_q;
  logic [LEN_W-1:0] base_total;

  assign base_total = clr ? '0 : total_q;
  assign total_now  = base_total + LEN_W'(pay);
  assign over_now   = (!clr && over_q) || (pay && base_total >= need);
  assign odd_now    = (pkt_start ? 1'b0 : odd_q) ^ pay;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      over_q  <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      total_q <= total_now;
      over_q  <= over_now;
      odd_q   <= odd_now;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned CAP_W    = 16,
  parameter int unsigned IDX_W    = 4,
  parameter logic [15:0] START_ID = 16'd9,
  parameter logic [15:0] CONT_ID  = 16'd5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [CAP_W-1:0] cap_bits,
  input  logic             desc_accept,
  output logic             desc_valid,
  output logic             desc_write,
  output logic             desc_poll,
  output logic             desc_wren,
  output logic [4:0]       desc_dummy,
  output logic             desc_dtr,
  output logic [1:0]       desc_width,
  output logic [1:0]       desc_mode,
  output logic [2:0]       desc_addr_len,
  output logic [1:0]       desc_op_len,
  output logic [15:0]      desc_count,
  output logic             err_valid,
  output logic [15:0]      err_code
);
  localparam int unsigned HDR_B   = (CNT_W + FLAG_W) / 8;
  localparam int unsigned PAY_OFF = 2 + HDR_B;
  localparam int unsigned LEN_W   = CNT_W + 2;

  cmd_e               cmd_q, cmd_d;
  logic [IDX_W-1:0]   bidx;
  logic [15:0]        id_now;
  logic [8*HDR_B-1:0] hdr_now;
  logic               drop_now;
  logic [FLAG_W-1:0]  flags_now;
  logic [CNT_W-1:0]   count_now;
  logic               ext_off, rsvd_bad, unsup;
  logic [LEN_W-1:0]   need, total_now;
  logic               over_now, odd_now;
  logic               is_start, is_cont, pay, clr, eop_evt;
  logic               len_done, len_bad;
  logic               fire_err, fire_desc;
  logic [15:0]        code_d;
  desc_t              desc_q;
  logic               err_valid_q;
  logic [15:0]        err_code_q;

  fcd_hdr_parse #(.IDX_W(IDX_W), .HDR_B(HDR_B)) u_hdr (
    .clk(clk), .rst(rst), .beat(in_valid), .sop(in_sop), .data(in_data),
    .cap_en(cmd_q == CMD_IDLE), .hold(cmd_q == CMD_HOLD),
    .bidx(bidx), .id_now(id_now), .hdr_now(hdr_now), .drop_now(drop_now)
  );

  assign count_now = hdr_now[CNT_W-1:0];
  assign flags_now = hdr_now[CNT_W +: FLAG_W];

  fcd_flag_check #(.CAP_W(CAP_W), .LEN_W(LEN_W)) u_chk (
    .flags(flags_now), .caps(cap_bits), .count(count_now),
    .ext_off(ext_off), .rsvd_bad(rsvd_bad), .unsup(unsup), .need(need)
  );

  assign is_start = (id_now == START_ID);
  assign is_cont  = (id_now == CONT_ID);
  assign pay      = in_valid && !drop_now &&
                    (((cmd_q == CMD_IDLE) && is_start && bidx == IDX_W'(PAY_OFF)) ||
                     ((cmd_q == CMD_COLL) && is_cont && bidx >= IDX_W'(2)));
  assign clr      = in_valid && in_sop && (cmd_q == CMD_IDLE);
  assign eop_evt  = in_valid && in_eop && !drop_now;

  fcd_len_track #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .clr(clr), .pkt_start(in_valid && in_sop),
    .pay(pay), .need(need),
    .total_now(total_now), .over_now(over_now), .odd_now(odd_now)
  );

  assign len_done = !over_now && (total_now == need);
  assign len_bad  = over_now || odd_now;

  always_comb begin
    cmd_d     = cmd_q;
    fire_err  = 1'b0;
    fire_desc = 1'b0;
    code_d    = err_code_q;
    unique case (cmd_q)
      CMD_IDLE: begin
        if (eop_evt && bidx != IDX_W'(0) && is_start) begin
          if (ext_off) begin
            fire_err = 1'b1; code_d = ERR_UNEXPECTED;
          end else if (bidx < IDX_W'(PAY_OFF - 1)) begin
            fire_err = 1'b1; code_d = ERR_MALFORMED;
          end else if (rsvd_bad) begin
            fire_err = 1'b1; code_d = ERR_MALFORMED;
          end else if (unsup) begin
            fire_err = 1'b1; code_d = ERR_UNSUP_MODE;
          end else if (len_done) begin
            fire_desc = 1'b1; cmd_d = CMD_HOLD;
          end else if (len_bad) begin
            fire_err = 1'b1; code_d = ERR_MALFORMED;
          end else begin
            cmd_d = CMD_COLL;
          end
        end
      end
      CMD_COLL: begin
        if (eop_evt) begin
          if (bidx == IDX_W'(0) || !is_cont) begin
            fire_err = 1'b1; code_d = ERR_MALFORMED; cmd_d = CMD_IDLE;
          end else if (len_done) begin
            fire_desc = 1'b1; cmd_d = CMD_HOLD;
          end else if (len_bad) begin
            fire_err = 1'b1; code_d = ERR_MALFORMED; cmd_d = CMD_IDLE;
          end
        end
      end
      CMD_HOLD: if (desc_accept) cmd_d = CMD_IDLE;
      default:  cmd_d = CMD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= CMD_IDLE;
      desc_q      <= '0;
      err_valid_q <= 1'b0;
      err_code_q  <= '0;
    end else begin
      cmd_q       <= cmd_d;
      err_valid_q <= fire_err;
      err_code_q  <= code_d;
      if (fire_desc) desc_q <= decode_flags(flags_now, count_now);
    end
  end

  assign desc_valid    = (cmd_q == CMD_HOLD);
  assign desc_write    = desc_q.write;
  assign desc_poll     = desc_q.poll;
  assign desc_wren     = desc_q.wren;
  assign desc_dummy    = desc_q.dummy;
  assign desc_dtr      = desc_q.dtr;
  assign desc_width    = desc_q.width;
  assign desc_mode     = desc_q.mode;
  assign desc_addr_len = desc_q.addr_len;
  assign desc_op_len   = desc_q.op_len;
  assign desc_count    = desc_q.count;
  assign err_valid     = err_valid_q;
  assign err_code      = err_code_q;

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(err_valid && desc_valid));

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);

  assert_after_eop_R11: assert property (@(posedge clk) disable iff (rst)
    (err_valid || $rose(desc_valid)) |-> $past(in_valid && in_eop));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_accept) |=> (desc_valid && $stable(desc_q)));

  assert_code_set_R7: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code == ERR_UNEXPECTED || err_code == ERR_MALFORMED ||
                   err_code == ERR_UNSUP_MODE));

  assert_unexpected_cap_R3: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code == ERR_UNEXPECTED) |-> !$past(cap_bits[1]));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int CONT = 5;
  localparam int START = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, desc_accept = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [15:0] cap_bits = 16'h003F;
  logic        desc_valid, desc_write, desc_poll, desc_wren, desc_dtr, err_valid;
  logic [4:0]  desc_dummy;
  logic [1:0]  desc_width, desc_mode, desc_op_len;
  logic [2:0]  desc_addr_len;
  logic [15:0] desc_count, err_code;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .cap_bits(cap_bits),
    .desc_accept(desc_accept), .desc_valid(desc_valid), .desc_write(desc_write),
    .desc_poll(desc_poll), .desc_wren(desc_wren), .desc_dummy(desc_dummy),
    .desc_dtr(desc_dtr), .desc_width(desc_width), .desc_mode(desc_mode),
    .desc_addr_len(desc_addr_len), .desc_op_len(desc_op_len),
    .desc_count(desc_count), .err_valid(err_valid), .err_code(err_code)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R10";

  // reference model state
  int          m_cmd = 0;      // 0 idle, 1 collecting, 2 holding
  bit          m_drop = 0;
  logic [7:0]  pkt[$];
  logic [7:0]  txq[$];
  int          m_total = 0;
  logic [31:0] m_flags = '0;
  logic [15:0] m_count = '0;
  logic [31:0] d_flags = '0;
  logic [15:0] d_count = '0;
  bit          exp_err = 0;
  logic [15:0] exp_code = '0;
  bit          seen_err = 0, seen_desc = 0;
  logic [15:0] seen_code = '0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_error(logic [15:0] c);
    exp_err = 1; exp_code = c; m_cmd = 0;
  endtask

  task automatic process_pkt();
    int n = pkt.size();
    int id = (n >= 2) ? int'({pkt[1], pkt[0]}) : -1;
    int pay;
    int need;
    if (m_cmd == 0) begin
      if (n < 2 || id != START) return;
      if (!cap_bits[1]) begin m_error(16'h0008); return; end
      if (n < 8) begin m_error(16'h0002); return; end
      m_count = {pkt[3], pkt[2]};
      m_flags = {pkt[7], pkt[6], pkt[5], pkt[4]};
      if ((m_flags & 32'h4FFF_8000) != 0) begin m_error(16'h0002); return; end
      begin
        int w = int'(m_flags[8:7]);
        bit lane_bad = (m_flags[6:5] != 0) && (w != 0) && !cap_bits[w+1];
        bit dtr_bad  = m_flags[9] && !cap_bits[5];
        bit dum_bad  = (m_flags[14:10] != 0) && (cap_bits[4:2] == 0);
        if (lane_bad || dtr_bad || dum_bad) begin m_error(16'h000A); return; end
      end
      pay = n - 8; m_total = pay;
    end else begin
      if (n < 2 || id != CONT) begin m_error(16'h0002); return; end
      pay = n - 2; m_total += pay;
    end
    need = int'(m_flags[1:0]) + int'(m_flags[4:2]) + int'(m_flags[28]) +
           (m_flags[31] ? int'(m_count) + 1 : 0);
    if (m_total == need) begin
      m_cmd = 2; d_flags = m_flags; d_count = m_count;
    end else if (m_total > need || (pay % 2) != 0) m_error(16'h0002);
    else m_cmd = 1;
  endtask

  task automatic model_step();
    bit was_hold = (m_cmd == 2);
    exp_err = 0;
    if (in_valid) begin
      if (in_sop) begin m_drop = was_hold; pkt.delete(); end
      if (!m_drop) pkt.push_back(in_data);
      if (in_eop && !m_drop) process_pkt();
    end
    if (was_hold && desc_accept) m_cmd = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk); #2;
    cmp({cur_req, " desc_valid"}, 32'(desc_valid), 32'(m_cmd == 2));
    cmp({cur_req, " err_valid"}, 32'(err_valid), 32'(exp_err));
    cmp({cur_req, " err_code"}, 32'(err_code), 32'(exp_code));
    if (m_cmd == 2) begin
      cmp({cur_req, " R2 descriptor"},
          {desc_write, desc_poll, desc_wren, desc_dummy, desc_dtr, desc_width,
           desc_mode, desc_addr_len, desc_op_len},
          32'({d_flags[31], d_flags[29], d_flags[28], d_flags[14:10], d_flags[9],
               d_flags[8:7], d_flags[6:5], d_flags[4:2], d_flags[1:0]}));
      cmp({cur_req, " R2 count"}, 32'(desc_count), 32'(d_count));
    end
    if (err_valid) begin seen_err = 1; seen_code = err_code; end
    if (desc_valid) seen_desc = 1;
    in_valid = 0; in_sop = 0; in_eop = 0; desc_accept = 0;
  endtask

  function automatic logic [31:0] mkf(int op, int ad, int md, int wd, bit dtr,
                                      int dum, bit wren, bit poll, bit wr);
    return (32'(op) & 3) | ((32'(ad) & 7) << 2) | ((32'(md) & 3) << 5) |
           ((32'(wd) & 3) << 7) | (32'(dtr) << 9) | ((32'(dum) & 31) << 10) |
           (32'(wren) << 28) | (32'(poll) << 29) | (32'(wr) << 31);
  endfunction

  task automatic push_start(logic [15:0] cnt, logic [31:0] fl, int npay);
    txq.push_back(8'(START)); txq.push_back(8'h00);
    txq.push_back(cnt[7:0]); txq.push_back(cnt[15:8]);
    for (int i = 0; i < 4; i++) txq.push_back(fl[8*i +: 8]);
    for (int i = 0; i < npay; i++) txq.push_back(8'(i * 7 + 1));
  endtask

  task automatic push_pkt(int id, int npay);
    txq.push_back(8'(id)); txq.push_back(8'(id >> 8));
    for (int i = 0; i < npay; i++) txq.push_back(8'(i * 3 + 2));
  endtask

  task automatic flush(bit acc_first);
    int n = txq.size();
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = txq[i]; in_sop = (i == 0); in_eop = (i == n - 1);
      desc_accept = acc_first && (i == 0);
      tick();
    end
    txq.delete();
  endtask

  task automatic begin_case(string r);
    cur_req = r; seen_err = 0; seen_desc = 0; seen_code = '0;
  endtask

  task automatic outcome(bit want_desc, bit want_err, logic [15:0] code);
    tick();
    cmp({cur_req, " outcome descriptor"}, 32'(seen_desc), 32'(want_desc));
    cmp({cur_req, " outcome error"}, 32'(seen_err), 32'(want_err));
    if (want_err) cmp({cur_req, " outcome code"}, 32'(seen_code), 32'(code));
    if (desc_valid) begin desc_accept = 1; tick(); end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    cmp("R10 desc_valid", 32'(desc_valid), 0);
    cmp("R10 err_valid", 32'(err_valid), 0);
    cmp("R10 err_code", 32'(err_code), 0);
    rst = 0;
    tick();

    // R1 / R2: read with no payload after header fields, need = 1 + 3 = 4
    begin_case("R1");
    push_start(16'h0123, mkf(1, 3, 2, 2, 1, 8, 0, 1, 0), 4);
    flush(0);
    cmp("R2 op_len", 32'(desc_op_len), 1);
    cmp("R2 addr_len", 32'(desc_addr_len), 3);
    cmp("R2 mode", 32'(desc_mode), 2);
    cmp("R2 width", 32'(desc_width), 2);
    cmp("R2 dtr", 32'(desc_dtr), 1);
    cmp("R2 dummy", 32'(desc_dummy), 8);
    cmp("R2 poll", 32'(desc_poll), 1);
    cmp("R2 write", 32'(desc_write), 0);
    cmp("R2 count", 32'(desc_count), 32'h0123);
    // R8 held across idle cycles and a packet that starts while holding
    cur_req = "R8";
    repeat (3) tick();
    push_start(16'd0, mkf(1, 0, 0, 0, 0, 0, 0, 0, 0), 1);
    flush(0);
    cmp("R8 still held", 32'(desc_valid), 1);
    cmp("R8 dropped packet raised no error", 32'(seen_err), 0);
    outcome(1, 0, 0);

    // R8 packet starting in the accept cycle is dropped
    begin_case("R8");
    push_start(16'd0, mkf(1, 0, 0, 0, 0, 0, 0, 0, 0), 1);
    flush(0);
    push_start(16'd0, mkf(1, 0, 0, 0, 0, 0, 0, 0, 0), 1);
    flush(1);
    tick();
    cmp("R8 accept-cycle packet dropped", 32'(desc_valid), 0);

    // R6 write spread over three packets: need = 1+3+1+100 = 105
    begin_case("R6");
    push_start(16'd99, mkf(1, 3, 0, 0, 0, 0, 1, 1, 1), 56); flush(0);
    push_pkt(CONT, 48); flush(0);
    cmp("R6 not yet complete", 32'(desc_valid), 0);
    push_pkt(CONT, 1); flush(0);
    outcome(1, 0, 0);

    // R7 odd non-final packet
    begin_case("R7");
    push_start(16'd99, mkf(1, 3, 0, 0, 0, 0, 1, 0, 1), 55); flush(0);
    outcome(0, 1, 16'h0002);
    // R7 overrun by one byte
    begin_case("R7");
    push_start(16'd0, mkf(1, 3, 0, 0, 0, 0, 0, 0, 0), 5); flush(0);
    outcome(0, 1, 16'h0002);
    // R7 overrun in a continuation
    begin_case("R7");
    push_start(16'd9, mkf(0, 0, 0, 0, 0, 0, 0, 0, 1), 4); flush(0);
    push_pkt(CONT, 8); flush(0);
    outcome(0, 1, 16'h0002);
    // R7 wrong id while collecting
    begin_case("R7");
    push_start(16'd99, mkf(1, 3, 0, 0, 0, 0, 1, 0, 1), 56); flush(0);
    push_pkt(3, 4); flush(0);
    outcome(0, 1, 16'h0002);
    // R7 short header
    begin_case("R7");
    for (int i = 0; i < 6; i++) txq.push_back(i == 0 ? 8'(START) : 8'h00);
    flush(0);
    outcome(0, 1, 16'h0002);

    // R3 extensions not advertised
    begin_case("R3");
    cap_bits = 16'h0001;
    push_start(16'd0, mkf(1, 0, 0, 0, 0, 0, 0, 0, 0), 1); flush(0);
    outcome(0, 1, 16'h0008);
    // R11 priority: capability bit 1 beats reserved bits
    begin_case("R11");
    push_start(16'd0, 32'h0010_0001, 1); flush(0);
    outcome(0, 1, 16'h0008);

    // R4 reserved bits
    cap_bits = 16'h003F;
    begin_case("R4");
    push_start(16'd0, 32'h0010_0001, 1); flush(0);
    outcome(0, 1, 16'h0002);
    begin_case("R4");
    push_start(16'd0, 32'h4000_0001, 1); flush(0);
    outcome(0, 1, 16'h0002);

    // R5 capability checks with only dual advertised
    cap_bits = 16'h0006;
    begin_case("R5");
    push_start(16'd0, mkf(1, 0, 1, 2, 0, 0, 0, 0, 0), 1); flush(0);
    outcome(0, 1, 16'h000A);
    begin_case("R5");
    push_start(16'd0, mkf(1, 0, 1, 1, 1, 0, 0, 0, 0), 1); flush(0);
    outcome(0, 1, 16'h000A);
    begin_case("R5");
    push_start(16'd0, mkf(1, 0, 3, 1, 0, 6, 0, 0, 0), 1); flush(0);
    outcome(1, 0, 0);
    begin_case("R5");
    push_start(16'd0, mkf(1, 0, 0, 3, 0, 0, 0, 0, 0), 1); flush(0);
    outcome(1, 0, 0);
    cap_bits = 16'h0002;
    begin_case("R5");
    push_start(16'd0, mkf(1, 0, 0, 0, 0, 4, 0, 0, 0), 1); flush(0);
    outcome(0, 1, 16'h000A);
    // R11 priority: reserved beats unsupported
    begin_case("R11");
    push_start(16'd0, mkf(1, 0, 1, 2, 0, 0, 0, 0, 0) | 32'h0800_0000, 1); flush(0);
    outcome(0, 1, 16'h0002);

    // R9 foreign packets in idle
    cap_bits = 16'h003F;
    begin_case("R9");
    push_pkt(3, 10); flush(0);
    push_pkt(CONT, 6); flush(0);
    txq.push_back(8'(START)); flush(0);
    tick();
    cmp("R9 no error", 32'(seen_err), 0);
    cmp("R9 no descriptor", 32'(seen_desc), 0);
    push_start(16'd1, mkf(0, 2, 0, 0, 0, 0, 0, 0, 1), 4); flush(0);
    outcome(1, 0, 0);

    // R11 back-to-back: error packet then immediate good packet
    begin_case("R11");
    push_start(16'd0, 32'h0010_0000, 0); flush(0);
    push_start(16'd0, mkf(0, 0, 0, 0, 0, 0, 0, 0, 0), 0); flush(0);
    outcome(1, 1, 16'h0002);

    repeat (3) tick();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule